// File: doc/BRIEF.md
# Predictive dead-time step controller

This block sets the two dead times of a synchronous buck half-bridge from what it saw in the previous switching period. One 4-bit delay code belongs to the turn-on edge, where the synchronous switch turns on after PWM falls. A second code belongs to the turn-off edge, where the control switch turns on after PWM rises. Each code picks a tap of an external delay line of 16 positions, each tap worth roughly 4 ns.

Once per period, each edge latches a body-diode conduction indicator a fixed number of clock cycles after its PWM edge. On the turn-on edge the indicator is the AND of the two "low" sense bits, drain-source voltage low and gate-source voltage low. On the turn-off edge it is a comparator bit that fires when drain-source voltage falls below about -0.3 V. That stricter threshold keeps noise from shortening the dead time into shoot-through.

At the next PWM rising edge each code moves one step. It steps down when conduction was seen and up when it was not. In steady state each code therefore toggles between two neighbouring taps. The block also produces the two gate commands. In these, one clock cycle stands for one delay tap, so the dead time the codes produce can be observed.

Top module: `dt_step_ctrl`

## Requirements
- R1: After reset both codes read 15 and both gate outputs are low.
- R2: The turn-on indicator is `vds_low_i & vgs_low_i`, sampled at the 4th rising clock edge after PWM is driven low (the edge that first sees PWM low counts as the 1st). At the next PWM rise the turn-on code drops by 1 if the indicator was 1, and rises by 1 if it was 0.
- R3: The turn-off indicator is `vds_neg_i`, sampled at the 4th rising clock edge after PWM is driven high. At the following PWM rise the turn-off code drops by 1 if the indicator was 1, and rises by 1 if it was 0.
- R4: Both codes saturate at 0 and at 15 and never wrap.
- R5: The low-side gate goes high at the (N+1)-th rising clock edge after PWM goes low, where N is the turn-on code. It goes low at the first edge that sees PWM high.
- R6: The high-side gate goes high at the (N+1)-th rising clock edge after PWM goes high, where N is the turn-off code as updated at that same rise. It goes low at the first edge that sees PWM low.
- R7: The two gate outputs are never high together, and a gate that has turned on stays on for the rest of its PWM phase.
- R8: Sense inputs that change after the sampling edge of a phase have no effect on the codes.
- R9: A code whose edge took no sample in the previous period holds its value, and the two codes move independently of each other.
- R10: Indicators that alternate period by period make a code toggle between two adjacent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period equals one delay tap |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command, high = control switch phase |
| vds_low_i | input | 1 | Synchronous switch drain-source voltage is low |
| vgs_low_i | input | 1 | Synchronous switch gate-source voltage is low |
| vds_neg_i | input | 1 | Drain-source voltage below the negative threshold |
| on_code_o | output | 4 | Turn-on delay code (after PWM fall) |
| off_code_o | output | 4 | Turn-off delay code (after PWM rise) |
| hs_gate_o | output | 1 | Control switch gate command |
| ls_gate_o | output | 1 | Synchronous switch gate command |

## Verification
The hardest state to reach is a code that sits at a rail while its indicator keeps pushing it outward. Getting there needs about fifteen periods in which the indicator is held one way. Long directed runs drive both codes down to 0 and back up to 15, so the rails are held for several periods each.

The second hard case is a sense bit that changes right after its sampling edge. Directed and random phases flip the sense inputs one cycle after that edge. The bench model keeps the value that was present when the sample was taken.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int unsigned N_EDGE   = 2;
  localparam int unsigned EDGE_ON  = 0;  // PWM fall, synchronous switch turns on
  localparam int unsigned EDGE_OFF = 1;  // PWM rise, control switch turns on
endpackage

// File: rtl/dt_pwm_edge.sv
module dt_pwm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic rise_o,
  output logic fall_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_i;
  end

  assign rise_o = pwm_i & ~pwm_q;
  assign fall_o = ~pwm_i & pwm_q;
endmodule

// File: rtl/dt_code_step.sv
module dt_code_step #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SAMPLE_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_start_i,
  input  logic              upd_i,
  input  logic              flag_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam int unsigned       CNT_W    = $clog2(SAMPLE_DLY + 1) + 1;

  logic [CNT_W-1:0]  win_cnt;
  logic              win_act, flag_q, valid_q, take;
  logic [CODE_W-1:0] code_q, code_d;

  // latch at the (SAMPLE_DLY+1)-th edge counting the edge-detect edge
  assign take = win_act & ~win_start_i & (win_cnt == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      win_act <= 1'b0;
      flag_q  <= 1'b0;
    end else if (win_start_i) begin
      win_cnt <= CNT_W'(SAMPLE_DLY);
      win_act <= 1'b1;
    end else if (win_act) begin
      win_cnt <= win_cnt - CNT_W'(1);
      if (take) begin
        flag_q  <= flag_i;
        win_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= 1'b0;
    else if (take)  valid_q <= 1'b1;
    else if (upd_i) valid_q <= 1'b0;
  end

  always_comb begin
    code_d = code_q;
    if (upd_i && valid_q) begin
      if (flag_q) code_d = (code_q == '0)      ? code_q : code_q - CODE_W'(1);
      else        code_d = (code_q == CODE_MAX) ? code_q : code_q + CODE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_MAX;  // worst-case safe dead time
    else         code_q <= code_d;
  end

  assign code_o     = code_q;
  assign code_nxt_o = code_d;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(code_q));
  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ((int'(code_q) - int'($past(code_q))) <= 1 &&
               (int'(code_q) - int'($past(code_q))) >= -1));
  assert_no_wrap_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == CODE_MAX) |=> (code_q != '0));
  assert_no_wrap_bot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == '0) |=> (code_q != CODE_MAX));
endmodule

// File: rtl/dt_gate_timer.sv
module dt_gate_timer #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              gate_o
);
  logic              arm_q;
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      arm_q <= 1'b0;
    end else if (start_i) begin
      arm_q <= 1'b1;
      cnt_q <= code_i;
    end else if (arm_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CODE_W'(1);
    end
  end

  assign gate_o = arm_q & (cnt_q == '0);

  assert_gate_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !gate_o);
  assert_dead_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && code_i != '0) |=> !gate_o);
  assert_gate_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !stop_i) |=> gate_o);
endmodule

// File: rtl/dt_step_ctrl.sv
module dt_step_ctrl #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SAMPLE_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic              vds_low_i,
  input  logic              vgs_low_i,
  input  logic              vds_neg_i,
  output logic [CODE_W-1:0] on_code_o,
  output logic [CODE_W-1:0] off_code_o,
  output logic              hs_gate_o,
  output logic              ls_gate_o
);
  import dt_pkg::*;

  logic              rise, fall;
  logic              ev   [N_EDGE];
  logic              flag [N_EDGE];
  logic              gate [N_EDGE];
  logic [CODE_W-1:0] code [N_EDGE];
  logic [CODE_W-1:0] nxt  [N_EDGE];

  dt_pwm_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign ev[EDGE_ON]    = fall;
  assign ev[EDGE_OFF]   = rise;
  assign flag[EDGE_ON]  = vds_low_i & vgs_low_i;  // both low: diode conducting
  assign flag[EDGE_OFF] = vds_neg_i;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    localparam int unsigned OPP = N_EDGE - 1 - g;

    dt_code_step #(.CODE_W(CODE_W), .SAMPLE_DLY(SAMPLE_DLY)) u_code (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .win_start_i (ev[g]),
      .upd_i       (rise),  // period boundary
      .flag_i      (flag[g]),
      .code_o      (code[g]),
      .code_nxt_o  (nxt[g])
    );

    dt_gate_timer #(.CODE_W(CODE_W)) u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (ev[g]),
      .stop_i  (ev[OPP]),
      .code_i  (nxt[g]),
      .gate_o  (gate[g])
    );
  end

  assign on_code_o  = code[EDGE_ON];
  assign off_code_o = code[EDGE_OFF];
  assign ls_gate_o  = gate[EDGE_ON];
  assign hs_gate_o  = gate[EDGE_OFF];

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));
endmodule

// File: tb/dt_step_ctrl_tb_top.sv
module dt_step_ctrl_tb_top;
  localparam int SAMPLE_DLY = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwm_i = 1'b0, vds_low_i = 1'b0, vgs_low_i = 1'b0, vds_neg_i = 1'b0;
  logic [3:0] on_code_o, off_code_o;
  logic       hs_gate_o, ls_gate_o;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  int  exp_on = 15, exp_off = 15;
  bit  have_on = 1'b0, have_off = 1'b0, on_s = 1'b0, off_s = 1'b0;

  always #4 clk_i = ~clk_i;

  dt_step_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i),
    .vds_low_i(vds_low_i), .vgs_low_i(vgs_low_i), .vds_neg_i(vds_neg_i),
    .on_code_o(on_code_o), .off_code_o(off_code_o),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o)
  );

  function automatic int step(input int c, input bit f);
    if (f) return (c == 0) ? 0 : c - 1;
    return (c == 15) ? 15 : c + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one PWM phase; fa/fb are the sense values, late flips them after sampling
  task automatic do_phase(input bit lvl, input int len, input bit fa, input bit fb,
                          input bit late, input string tag);
    int first = -1;
    bit ovl = 1'b0, drop = 1'b0, g, o;
    int exp_dt;
    @(negedge clk_i);
    pwm_i = lvl;
    if (lvl) begin
      vds_neg_i = fa;
      if (have_off) exp_off = step(exp_off, off_s);
      if (have_on)  exp_on  = step(exp_on, on_s);
      have_off = 1'b0; have_on = 1'b0;
      off_s = fa; have_off = 1'b1;
      exp_dt = exp_off;
    end else begin
      vds_low_i = fa; vgs_low_i = fb;
      on_s = fa & fb; have_on = 1'b1;
      exp_dt = exp_on;
    end
    for (int i = 1; i <= len; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (i == 1) begin
        chk(on_code_o == 4'(exp_on), {tag, " R2 turn-on code"}, on_code_o, exp_on);
        chk(off_code_o == 4'(exp_off), {tag, " R3 turn-off code"}, off_code_o, exp_off);
      end
      g = lvl ? hs_gate_o : ls_gate_o;
      o = lvl ? ls_gate_o : hs_gate_o;
      if (o) ovl = 1'b1;
      if (g && first < 0) first = i;
      if (!g && first >= 0) drop = 1'b1;
      if (late && i == SAMPLE_DLY + 1) begin  // R8: change after sample edge
        if (lvl) vds_neg_i = ~vds_neg_i;
        else begin vds_low_i = ~vds_low_i; vgs_low_i = ~vgs_low_i; end
      end
    end
    chk(first == exp_dt + 1, lvl ? "R6 high-side dead time" : "R5 low-side dead time",
        first, exp_dt + 1);
    chk(!ovl && !drop, "R7 gate overlap or early drop", {30'd0, ovl, drop}, 0);
  endtask

  task automatic period(input int len, input bit on_f, input bit off_f,
                        input bit late, input string tag);
    do_phase(1'b1, len, off_f, 1'b0, late, tag);
    do_phase(1'b0, len, on_f, on_f, late, tag);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd20250);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(on_code_o == 4'd15, "R1 reset turn-on code", on_code_o, 15);
    chk(off_code_o == 4'd15, "R1 reset turn-off code", off_code_o, 15);
    chk(!hs_gate_o && !ls_gate_o, "R1 reset gates", {hs_gate_o, ls_gate_o}, 0);

    // R9: first rise has no samples, codes hold at 15
    period(20, 1'b1, 1'b1, 1'b0, "R9 hold");
    // R4: run down to 0 and sit there
    for (int k = 0; k < 20; k++) period(20, 1'b1, 1'b1, 1'b0, "R4 floor");
    chk(on_code_o == 4'd0 && off_code_o == 4'd0, "R4 floor reached",
        {on_code_o, off_code_o}, 0);
    // R4: run back up to 15
    for (int k = 0; k < 20; k++) period(20, 1'b0, 1'b0, 1'b0, "R4 ceiling");
    chk(on_code_o == 4'd15 && off_code_o == 4'd15, "R4 ceiling reached",
        {on_code_o, off_code_o}, 8'hff);
    // R9: opposite indicators, codes diverge
    for (int k = 0; k < 6; k++) period(20, 1'b1, 1'b0, 1'b0, "R9 independent");
    // R10: alternate indicators
    for (int k = 0; k < 10; k++) period(20, k[0], ~k[0], 1'b0, "R10 dither");
    // R8: flips after sampling
    for (int k = 0; k < 6; k++) period(20, k[1], k[0], 1'b1, "R8 late flip");
    // random mix
    for (int k = 0; k < 80; k++) begin
      int len;
      bit a, b, c, lt;
      len = 20 + int'($urandom % 21);
      a = 1'($urandom); b = 1'($urandom); c = 1'($urandom); lt = 1'($urandom);
      do_phase(1'b1, len, c, 1'b0, lt, "R3 random");
      len = 20 + int'($urandom % 21);
      do_phase(1'b0, len, a, b, lt, "R2 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule